// File: doc/BRIEF.md
# 64-bit Compare-Match System Timer

This block is a free-running 64-bit up-counter with a 64-bit comparator behind a plain 32-bit register bus. Software starts and stops counting, loads either counter half, arms the comparator and reads a sticky event flag. The flag can drive a level interrupt. The counter advances once per clock, with no prescaler. Its live value is also driven out for use by neighbouring logic.

A match is a magnitude test: the counter at or above the comparator. An equality test would miss a target that is already behind the counter. In periodic mode, each match moves the comparator forward by a programmable 32-bit step, so events repeat at a fixed spacing without software rewriting the comparator. The counter is read as two 32-bit words with no snapshot between them. Software therefore reads high, low, then high again, and retries if the two high values differ.

Register access takes one cycle and has no handshake. A write is taken at the clock edge on which `reg_wr` is high. Read data is combinational and valid while `reg_rd` is high. The block never stalls the bus.

Top module: `cmp_timer`

## Requirements
- R1: The word offsets are fixed because software decodes them. 0x00 is the counter low word and 0x04 the counter high word. 0x08 is control, bits [3:0], and reads zero above them. 0x0C is status, bit 0 only. 0x10 and 0x14 are the comparator low and high words, and 0x18 is the step value. An unmapped offset reads zero, and `reg_rdata` is zero whenever `reg_rd` is low.
- R2: While control bit 0 (run) is 1, the counter rises by exactly one on each clock. While it is 0, the counter holds.
- R3: A write to a counter half loads that half at the next edge and leaves the other half unchanged. The counter does not increment in that cycle.
- R4: The counter halves are not captured together. A carry from the low word into the high word shows up between two separate reads.
- R5: Control bit 1 (compare enable) arms the comparator. While it is 1 and the counter is greater than or equal to the comparator, the event flag is 1 from the next edge.
- R6: While compare enable is 0, the event flag never sets, including when the comparator halves are rewritten.
- R7: Writing status with bit 0 = 1 clears the event flag. Writing it with bit 0 = 0 leaves the flag unchanged.
- R8: When a match and a clear fall in the same cycle, the flag stays set. Without periodic mode, it keeps being set for as long as the match condition holds.
- R9: While control bit 3 (periodic) is 1, each match adds the 32-bit step value to the comparator. A comparator write in the same cycle takes priority over that addition.
- R10: `irq` is 1 exactly when the event flag is 1 and control bit 2 (interrupt enable) is 1.
- R11: Reset clears the counter, comparator, step value, control and event flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter ticks on every rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W (5) | Byte offset of the register |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | BUS_W (32) | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | BUS_W (32) | Read data, valid while reg_rd is high |
| irq | output | 1 | Level interrupt |
| count | output | 2*BUS_W (64) | Live counter value |

## Verification
A wrong counter state shows up on `count` at the very next clock, because it drifts from a step of one or fails to hold. A wrong comparator or step value stays hidden until the next match. It then appears as an `irq` edge or a flag read that is early, late or missing, or as a comparator read-back that does not land on the expected multiple. A wrong flag shows up on `irq` in the same cycle when interrupts are enabled, and otherwise on the next status read. The reference model compares `count`, `irq` and every read on each clock, so any divergence is caught within the cycle in which it first reaches a port.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int OFF_CNT_LO = 'h00;
  localparam int OFF_CNT_HI = 'h04;
  localparam int OFF_CTRL   = 'h08;
  localparam int OFF_STAT   = 'h0C;
  localparam int OFF_CMP_LO = 'h10;
  localparam int OFF_CMP_HI = 'h14;
  localparam int OFF_STEP   = 'h18;

  // packed so that bit 0 of the control word is run
  typedef struct packed {
    logic periodic;
    logic irq_en;
    logic cmp_en;
    logic run;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
  parameter int BUS_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [1:0]           half_we,
  input  logic [BUS_W-1:0]     wdata,
  output logic [2*BUS_W-1:0]   cnt
);
  localparam int CNT_W = 2 * BUS_W;
  localparam int NHALF = CNT_W / BUS_W;

  logic [CNT_W-1:0] cnt_q, stepped, cnt_d;

  // any half write freezes the count for that cycle
  assign stepped = (run && half_we == 2'b00) ? cnt_q + CNT_W'(1) : cnt_q;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    assign cnt_d[h*BUS_W +: BUS_W] = half_we[h] ? wdata : stepped[h*BUS_W +: BUS_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && half_we == 2'b00) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && half_we == 2'b00) |=> $stable(cnt_q));
  p_lo_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (half_we == 2'b01) |=> (cnt_q[BUS_W-1:0] == $past(wdata)) &&
                           (cnt_q[CNT_W-1:BUS_W] == $past(cnt_q[CNT_W-1:BUS_W])));
endmodule

// File: rtl/tmr_compare.sv
`timescale 1ns/1ps
module tmr_compare #(
  parameter int BUS_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2*BUS_W-1:0]   cnt,
  input  logic                 cmp_en,
  input  logic                 periodic,
  input  logic [1:0]           half_we,
  input  logic                 step_we,
  input  logic                 clr,
  input  logic [BUS_W-1:0]     wdata,
  output logic [2*BUS_W-1:0]   cmp,
  output logic [BUS_W-1:0]     step,
  output logic                 flag
);
  localparam int CMP_W = 2 * BUS_W;
  localparam int NHALF = CMP_W / BUS_W;

  logic [CMP_W-1:0] cmp_q, cmp_d, advanced, base;
  logic [BUS_W-1:0] step_q;
  logic             flag_q, match;

  assign match    = cmp_en && (cnt >= cmp_q);
  assign advanced = cmp_q + CMP_W'(step_q);
  // a software write to the comparator overrides the periodic advance
  assign base     = (match && periodic && half_we == 2'b00) ? advanced : cmp_q;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    assign cmp_d[h*BUS_W +: BUS_W] = half_we[h] ? wdata : base[h*BUS_W +: BUS_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      step_q <= '0;
      flag_q <= 1'b0;
    end else begin
      cmp_q  <= cmp_d;
      if (step_we) step_q <= wdata;
      flag_q <= match | (flag_q & ~clr);
    end
  end

  assign cmp  = cmp_q;
  assign step = step_q;
  assign flag = flag_q;

  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(cmp_en));
  p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && cnt >= cmp_q) |=> flag_q);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !match) |=> !flag_q);
  p_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (match && periodic && half_we == 2'b00) |=> cmp_q == $past(cmp_q) + CMP_W'($past(step_q)));
  p_wr_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
    half_we[0] |=> cmp_q[BUS_W-1:0] == $past(wdata));
endmodule

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int BUS_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr,
  input  logic                 rd,
  input  logic [3:0]           ctl_wdata,
  input  logic [2*BUS_W-1:0]   cnt,
  input  logic [2*BUS_W-1:0]   cmp,
  input  logic [BUS_W-1:0]     step,
  input  logic                 flag,
  output tmr_ctrl_t            ctrl,
  output logic [1:0]           cnt_we,
  output logic [1:0]           cmp_we,
  output logic                 step_we,
  output logic                 clr,
  output logic [BUS_W-1:0]     rdata,
  output logic                 irq
);
  localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(OFF_CNT_LO);
  localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(OFF_CNT_HI);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_CMP_LO = ADDR_W'(OFF_CMP_LO);
  localparam logic [ADDR_W-1:0] A_CMP_HI = ADDR_W'(OFF_CMP_HI);
  localparam logic [ADDR_W-1:0] A_STEP   = ADDR_W'(OFF_STEP);

  tmr_ctrl_t ctrl_q;

  assign cnt_we  = {wr && addr == A_CNT_HI, wr && addr == A_CNT_LO};
  assign cmp_we  = {wr && addr == A_CMP_HI, wr && addr == A_CMP_LO};
  assign step_we = wr && addr == A_STEP;
  assign clr     = wr && addr == A_STAT && ctl_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n)                   ctrl_q <= '0;
    else if (wr && addr == A_CTRL) ctrl_q <= tmr_ctrl_t'(ctl_wdata);
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (addr)
        A_CNT_LO: rdata = cnt[BUS_W-1:0];
        A_CNT_HI: rdata = cnt[2*BUS_W-1:BUS_W];
        A_CTRL:   rdata = BUS_W'(ctrl_q);
        A_STAT:   rdata = BUS_W'(flag);
        A_CMP_LO: rdata = cmp[BUS_W-1:0];
        A_CMP_HI: rdata = cmp[2*BUS_W-1:BUS_W];
        A_STEP:   rdata = step;
        default:  rdata = '0;
      endcase
    end
  end

  assign ctrl = ctrl_q;
  assign irq  = flag & ctrl_q.irq_en;

  p_idle_rd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> rdata == '0);
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.irq_en |-> !irq);
  p_irq_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
endmodule

// File: rtl/cmp_timer.sv
`timescale 1ns/1ps
module cmp_timer
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int BUS_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic [BUS_W-1:0]     reg_wdata,
  input  logic                 reg_rd,
  output logic [BUS_W-1:0]     reg_rdata,
  output logic                 irq,
  output logic [2*BUS_W-1:0]   count
);
  tmr_ctrl_t          ctrl;
  logic [1:0]         cnt_we, cmp_we;
  logic               step_we, clr, flag;
  logic [2*BUS_W-1:0] cnt, cmp;
  logic [BUS_W-1:0]   step;

  tmr_regs #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
    .ctl_wdata(reg_wdata[3:0]), .cnt(cnt), .cmp(cmp), .step(step), .flag(flag),
    .ctrl(ctrl), .cnt_we(cnt_we), .cmp_we(cmp_we), .step_we(step_we), .clr(clr),
    .rdata(reg_rdata), .irq(irq)
  );

  tmr_counter #(.BUS_W(BUS_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .half_we(cnt_we),
    .wdata(reg_wdata), .cnt(cnt)
  );

  tmr_compare #(.BUS_W(BUS_W)) u_compare (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cmp_en(ctrl.cmp_en),
    .periodic(ctrl.periodic), .half_we(cmp_we), .step_we(step_we), .clr(clr),
    .wdata(reg_wdata), .cmp(cmp), .step(step), .flag(flag)
  );

  assign count = cnt;
endmodule

// File: tb/cmp_timer_test.sv
`timescale 1ns/1ps
module cmp_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic [63:0] count;

  int n_chk = 0, n_fail = 0;
  bit live = 0, done = 0;

  // behavioural reference state
  logic [63:0] m_cnt = '0, m_cmp = '0;
  logic [31:0] m_step = '0;
  logic [3:0]  m_ctl = '0;
  logic        m_flag = 1'b0;

  always #5 clk = ~clk;

  cmp_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .irq(irq), .count(count)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(logic [4:0] a);
    case (a)
      5'h00: return m_cnt[31:0];
      5'h04: return m_cnt[63:32];
      5'h08: return {28'b0, m_ctl};
      5'h0C: return {31'b0, m_flag};
      5'h10: return m_cmp[31:0];
      5'h14: return m_cmp[63:32];
      5'h18: return m_step;
      default: return 32'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = '0; m_cmp = '0; m_step = '0; m_ctl = '0; m_flag = 1'b0;
    end else begin
      bit hit;
      bit cnt_wr, cmp_wr;
      hit    = m_ctl[1] && (m_cnt >= m_cmp);
      cnt_wr = reg_wr && (reg_addr == 5'h00 || reg_addr == 5'h04);
      cmp_wr = reg_wr && (reg_addr == 5'h10 || reg_addr == 5'h14);
      if (reg_wr && reg_addr == 5'h0C && reg_wdata[0]) m_flag = 1'b0;
      if (hit) m_flag = 1'b1;
      if (hit && m_ctl[3] && !cmp_wr) m_cmp = m_cmp + {32'b0, m_step};
      if (!cnt_wr && m_ctl[0]) m_cnt = m_cnt + 1;
      if (reg_wr) begin
        case (reg_addr)
          5'h00: m_cnt[31:0]  = reg_wdata;
          5'h04: m_cnt[63:32] = reg_wdata;
          5'h08: m_ctl        = reg_wdata[3:0];
          5'h10: m_cmp[31:0]  = reg_wdata;
          5'h14: m_cmp[63:32] = reg_wdata;
          5'h18: m_step       = reg_wdata;
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison, half a period after the edge
  always @(negedge clk) begin
    if (live && rst_n) begin
      check("R2 count", count, m_cnt);
      check("R10 irq", {63'b0, irq}, {63'b0, m_flag & m_ctl[2]});
      check("R1 rdata", {32'b0, reg_rdata}, {32'b0, reg_rd ? m_read(reg_addr) : 32'b0});
    end
  end

  task automatic step_clk(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr_reg(logic [4:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step_clk(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [4:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #3 d = reg_rdata;
    @(posedge clk); #2;
    reg_rd = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step_clk(3);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, h1, h2;
    step_clk(1);
    do_reset();
    live = 1;

    // R11: every register is zero after reset
    for (int a = 0; a < 7; a++) begin
      rd_reg(5'(a * 4), v);
      check("R11 reset value", {32'b0, v}, 64'd0);
    end
    rd_reg(5'h1C, v);
    check("R1 unmapped read", {32'b0, v}, 64'd0);

    // R3: load halves while stopped
    wr_reg(5'h00, 32'hFFFF_FFFE);
    wr_reg(5'h04, 32'h0000_0007);
    rd_reg(5'h00, v); check("R3 low load", {32'b0, v}, 64'hFFFF_FFFE);
    rd_reg(5'h04, v); check("R3 high load", {32'b0, v}, 64'h7);

    // R4: start counting; the carry lands between separate reads
    wr_reg(5'h08, 32'h1);
    rd_reg(5'h00, v);
    rd_reg(5'h04, h1);
    rd_reg(5'h04, h2);
    check("R4 low word", {32'b0, v}, 64'hFFFF_FFFE);
    check("R4 high before carry", {32'b0, h1}, 64'h7);
    check("R4 high after carry", {32'b0, h2}, 64'h8);
    step_clk(5);

    // R6: comparator rewrites with compare disabled never set the flag
    wr_reg(5'h08, 32'h0);
    wr_reg(5'h04, 32'h0);
    wr_reg(5'h00, 32'd100);
    wr_reg(5'h10, 32'd50);
    wr_reg(5'h14, 32'd0);
    wr_reg(5'h10, 32'd20);
    step_clk(2);
    rd_reg(5'h0C, v); check("R6 no flag while disarmed", {32'b0, v}, 64'd0);

    // R5: counter above comparator (not equal) raises the flag; R10 irq follows
    wr_reg(5'h08, 32'h6);
    step_clk(1);
    rd_reg(5'h0C, v); check("R5 flag on greater", {32'b0, v}, 64'd1);
    check("R10 irq enabled", {63'b0, irq}, 64'd1);

    // R8: clear while the condition holds loses to the set
    wr_reg(5'h0C, 32'h1);
    rd_reg(5'h0C, v); check("R8 set wins", {32'b0, v}, 64'd1);

    // R7: disarm, then a zero write keeps the flag and a one write clears it
    wr_reg(5'h08, 32'h4);
    wr_reg(5'h0C, 32'h0);
    rd_reg(5'h0C, v); check("R7 zero write ignored", {32'b0, v}, 64'd1);
    wr_reg(5'h0C, 32'h1);
    rd_reg(5'h0C, v); check("R7 one write clears", {32'b0, v}, 64'd0);
    check("R10 irq low after clear", {63'b0, irq}, 64'd0);

    // R10: flag without interrupt enable keeps irq low
    wr_reg(5'h08, 32'h2);
    step_clk(2);
    check("R10 irq masked", {63'b0, irq}, 64'd0);
    wr_reg(5'h08, 32'h0);
    wr_reg(5'h0C, 32'h1);

    // R9: periodic advance by the step value
    wr_reg(5'h00, 32'd0);
    wr_reg(5'h10, 32'd10);
    wr_reg(5'h18, 32'd10);
    wr_reg(5'h08, 32'hB);
    step_clk(24);
    wr_reg(5'h08, 32'hA);
    rd_reg(5'h00, v); check("R9 count stop point", {32'b0, v}, 64'd25);
    rd_reg(5'h10, v); check("R9 comparator advanced twice", {32'b0, v}, 64'd30);

    // R9: a lower comparator catches up through >= including equality
    wr_reg(5'h10, 32'd5);
    step_clk(6);
    rd_reg(5'h10, v); check("R9 catch-up comparator", {32'b0, v}, 64'd35);

    // R11: reset in mid-operation
    wr_reg(5'h08, 32'hF);
    step_clk(3);
    live = 0;
    do_reset();
    live = 1;
    check("R11 count after reset", count, 64'd0);
    rd_reg(5'h08, v); check("R11 control after reset", {32'b0, v}, 64'd0);
    rd_reg(5'h10, v); check("R11 comparator after reset", {32'b0, v}, 64'd0);
    rd_reg(5'h0C, v); check("R11 flag after reset", {32'b0, v}, 64'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule